// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block performs the privileged side of taking a trap on a processor core. When the pipeline raises a trap request it presents a cause number, a flag that marks the request as an interrupt, the faulting address and the PC of the trapping instruction. In that same cycle the unit decides whether the trap is handled in supervisor or in machine mode. At the next clock edge it loads the handler address, the cause, the saved PC and the trap value of the chosen mode. It also saves the old interrupt enable and the old privilege into the status fields and switches the current privilege.

The unit holds these control registers itself. It has two handler base registers, two delegation masks (one for exceptions and one for interrupts), the current privilege and the two interrupt enables. A simple configuration write port loads them. The saved cause, PC, trap value and status fields are visible as outputs.

A two-state machine sequences the entry. It sits in `ST_RUN` and takes the `RUN_TO_ENTRY` transition on a request. It stays in `ST_ENTRY` for exactly one cycle, during which the taken pulse and the new PC are valid. From there it takes `ENTRY_TO_RUN` when no request is present, or `ENTRY_TO_ENTRY` when a second request arrives back to back.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the privilege is machine (3). All saved cause, PC and trap-value registers, the status bits, both handler bases and both masks are zero, and `taken_o` is low.
- R2: A request sampled at a clock edge makes `taken_o` high for exactly the following cycle, with `new_pc_o` holding the handler base of the chosen mode. Consecutive requests produce consecutive pulses.
- R3: For an interrupt, the written cause register has bit 31 set and the interrupt number in its low bits. For an exception, bit 31 is clear and the low bits hold the (adjusted) cause code.
- R4: An exception with code 8 (environment call) is recorded as 8 from user, 9 from supervisor and 11 from machine privilege. Delegation is decided on the adjusted code.
- R5: A trap goes to supervisor mode only when the current privilege is user (0) or supervisor (1) and the mask bit indexed by the code is set. Otherwise it goes to machine mode, and a trap taken in machine mode always stays in machine mode.
- R6: Supervisor entry loads the supervisor handler base into the PC, the cause and PC into the supervisor cause and EPC registers, and the old supervisor enable into the supervisor previous-enable bit. It sets the supervisor previous-privilege bit to 1 when the old privilege was supervisor and to 0 when it was user, clears the supervisor enable and enters privilege 1. Machine-side registers are left unchanged.
- R7: Machine entry loads the machine handler base into the PC, the cause and PC into the machine registers and the old machine enable into the machine previous-enable bit. It stores the old 2-bit privilege in the machine previous-privilege field, clears the machine enable and enters privilege 3. Supervisor-side registers are left unchanged.
- R8: The trap value takes the faulting address only for exceptions with code 0, 1, 4, 5, 6, 7, 12, 13 or 15. For every other exception, and for every interrupt, it is written as zero.
- R9: The low two bits of both handler bases are forced to zero on write, so `new_pc_o` is always 4-byte aligned.
- R10: A privilege write of the reserved value 2 sets the privilege to user (0).
- R11: The configuration port writes `cfg_wdata_i` on `cfg_we_i`, and `cfg_sel_i` selects the target. The codes are 0 supervisor handler base, 1 machine handler base, 2 exception mask, 3 interrupt mask, 4 privilege (bits 1:0) and 5 enables (bit 0 supervisor, bit 1 machine). A write presented in the same cycle as a trap request is ignored.
- R12: Exceptions index only the exception mask and interrupts index only the interrupt mask. A code at or beyond the mask width `DELEG_W` is never delegated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_req_i | input | 1 | Trap request, one cycle per trap |
| trap_irq_i | input | 1 | Request is an interrupt |
| trap_cause_i | input | CAUSE_W | Cause or interrupt number |
| trap_addr_i | input | XLEN | Faulting address |
| trap_pc_i | input | XLEN | PC of the trapping instruction |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration target select |
| cfg_wdata_i | input | XLEN | Configuration write data |
| taken_o | output | 1 | One-cycle trap-taken pulse |
| new_pc_o | output | XLEN | Handler address |
| priv_o | output | 2 | Current privilege |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor saved PC |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine saved PC |
| mtval_o | output | XLEN | Machine trap value |

## Verification
The bench builds the unit with XLEN 32, CAUSE_W 6 and DELEG_W 16. The 6-bit cause field can then express codes 16 and above, which have no mask bit, so the rule that such codes are never delegated can be exercised even with a fully set exception mask. The 32-bit width places the interrupt flag at bit 31, where the bench checks it, and the 16-bit masks cover every environment-call and page-fault code.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        CFG_STVEC  = 3'd0,
        CFG_MTVEC  = 3'd1,
        CFG_EDELEG = 3'd2,
        CFG_IDELEG = 3'd3,
        CFG_PRIV   = 3'd4,
        CFG_ENABLE = 3'd5
    } cfg_sel_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_ENTRY = 1'b1
    } entry_state_e;

    localparam int unsigned ECALL_FROM_U = 8;
    localparam int unsigned ECALL_FROM_S = 9;
    localparam int unsigned ECALL_FROM_M = 11;

    function automatic priv_e legal_priv(input logic [1:0] raw);
        return (raw == 2'd2) ? PRIV_U : priv_e'(raw);
    endfunction

endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix
    import trap_pkg::*;
#(
    parameter int unsigned CAUSE_W = 6
) (
    input  logic               irq_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  priv_e              priv_i,
    output logic [CAUSE_W-1:0] code_o,
    output logic               keep_addr_o
);

    always_comb begin
        code_o = cause_i;
        if (!irq_i && cause_i == CAUSE_W'(ECALL_FROM_U)) begin
            unique case (priv_i)
                PRIV_U:  code_o = CAUSE_W'(ECALL_FROM_U);
                PRIV_S:  code_o = CAUSE_W'(ECALL_FROM_S);
                default: code_o = CAUSE_W'(ECALL_FROM_M);
            endcase
        end
    end

    // address-carrying exceptions: misaligned, access fault, page fault
    always_comb begin
        case (code_o)
            CAUSE_W'(0), CAUSE_W'(1), CAUSE_W'(4), CAUSE_W'(5),
            CAUSE_W'(6), CAUSE_W'(7), CAUSE_W'(12), CAUSE_W'(13),
            CAUSE_W'(15): keep_addr_o = !irq_i;
            default:      keep_addr_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int unsigned CAUSE_W = 6,
    parameter int unsigned DELEG_W = 16
) (
    input  logic               irq_i,
    input  logic [CAUSE_W-1:0] code_i,
    input  priv_e              priv_i,
    input  logic [DELEG_W-1:0] edeleg_i,
    input  logic [DELEG_W-1:0] ideleg_i,
    output logic               to_super_o
);

    logic [DELEG_W-1:0] mask_sel;
    logic [DELEG_W-1:0] mask_shift;
    logic               low_priv;

    assign mask_sel   = irq_i ? ideleg_i : edeleg_i;
    // shifting past the mask width yields zero: such codes never delegate
    assign mask_shift = mask_sel >> code_i;
    assign low_priv   = (priv_i == PRIV_U) || (priv_i == PRIV_S);
    assign to_super_o = low_priv && mask_shift[0];

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 6,
    parameter int unsigned DELEG_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               trap_req_i,
    input  logic               trap_irq_i,
    input  logic [CAUSE_W-1:0] trap_cause_i,
    input  logic [XLEN-1:0]    trap_addr_i,
    input  logic [XLEN-1:0]    trap_pc_i,
    input  logic               cfg_we_i,
    input  logic [2:0]         cfg_sel_i,
    input  logic [XLEN-1:0]    cfg_wdata_i,
    output logic               taken_o,
    output logic [XLEN-1:0]    new_pc_o,
    output logic [1:0]         priv_o,
    output logic               sie_o,
    output logic               spie_o,
    output logic               spp_o,
    output logic               mie_o,
    output logic               mpie_o,
    output logic [1:0]         mpp_o,
    output logic [XLEN-1:0]    scause_o,
    output logic [XLEN-1:0]    sepc_o,
    output logic [XLEN-1:0]    stval_o,
    output logic [XLEN-1:0]    mcause_o,
    output logic [XLEN-1:0]    mepc_o,
    output logic [XLEN-1:0]    mtval_o
);

    localparam int unsigned PAD_W = XLEN - 1 - CAUSE_W;

    entry_state_e state_q, state_d;
    priv_e              priv_q, mpp_q;
    logic               sie_q, spie_q, spp_q, mie_q, mpie_q;
    logic [XLEN-1:0]    stvec_q, mtvec_q, new_pc_q;
    logic [XLEN-1:0]    scause_q, sepc_q, stval_q, mcause_q, mepc_q, mtval_q;
    logic [DELEG_W-1:0] edeleg_q, ideleg_q;

    logic [CAUSE_W-1:0] code;
    logic               keep_addr;
    logic               to_super;
    logic [XLEN-1:0]    cause_full;
    logic [XLEN-1:0]    tval_next;
    logic [XLEN-1:0]    tvec_wr;

    trap_cause_fix #(.CAUSE_W(CAUSE_W)) fix_i (
        .irq_i       (trap_irq_i),
        .cause_i     (trap_cause_i),
        .priv_i      (priv_q),
        .code_o      (code),
        .keep_addr_o (keep_addr)
    );

    trap_route #(.CAUSE_W(CAUSE_W), .DELEG_W(DELEG_W)) route_i (
        .irq_i      (trap_irq_i),
        .code_i     (code),
        .priv_i     (priv_q),
        .edeleg_i   (edeleg_q),
        .ideleg_i   (ideleg_q),
        .to_super_o (to_super)
    );

    assign cause_full = {trap_irq_i, {PAD_W{1'b0}}, code};
    assign tval_next  = keep_addr ? trap_addr_i : '0;
    assign tvec_wr    = {cfg_wdata_i[XLEN-1:2], 2'b00};

    // next-state logic: RUN_TO_ENTRY, ENTRY_TO_ENTRY, ENTRY_TO_RUN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = trap_req_i ? ST_ENTRY : ST_RUN;
            ST_ENTRY: state_d = trap_req_i ? ST_ENTRY : ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_ENTRY: taken_o = 1'b1;
            default:  taken_o = 1'b0;
        endcase
    end

    // register bank: trap entry has priority over configuration writes
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            priv_q   <= PRIV_M;
            mpp_q    <= PRIV_U;
            sie_q    <= 1'b0;
            spie_q   <= 1'b0;
            spp_q    <= 1'b0;
            mie_q    <= 1'b0;
            mpie_q   <= 1'b0;
            stvec_q  <= '0;
            mtvec_q  <= '0;
            new_pc_q <= '0;
            scause_q <= '0;
            sepc_q   <= '0;
            stval_q  <= '0;
            mcause_q <= '0;
            mepc_q   <= '0;
            mtval_q  <= '0;
            edeleg_q <= '0;
            ideleg_q <= '0;
        end else if (trap_req_i) begin
            if (to_super) begin
                new_pc_q <= stvec_q;
                scause_q <= cause_full;
                sepc_q   <= trap_pc_i;
                stval_q  <= tval_next;
                spie_q   <= sie_q;
                spp_q    <= (priv_q == PRIV_S);
                sie_q    <= 1'b0;
                priv_q   <= PRIV_S;
            end else begin
                new_pc_q <= mtvec_q;
                mcause_q <= cause_full;
                mepc_q   <= trap_pc_i;
                mtval_q  <= tval_next;
                mpie_q   <= mie_q;
                mpp_q    <= priv_q;
                mie_q    <= 1'b0;
                priv_q   <= PRIV_M;
            end
        end else if (cfg_we_i) begin
            case (cfg_sel_e'(cfg_sel_i))
                CFG_STVEC:  stvec_q  <= tvec_wr;
                CFG_MTVEC:  mtvec_q  <= tvec_wr;
                CFG_EDELEG: edeleg_q <= cfg_wdata_i[DELEG_W-1:0];
                CFG_IDELEG: ideleg_q <= cfg_wdata_i[DELEG_W-1:0];
                CFG_PRIV:   priv_q   <= legal_priv(cfg_wdata_i[1:0]);
                CFG_ENABLE: begin
                    sie_q <= cfg_wdata_i[0];
                    mie_q <= cfg_wdata_i[1];
                end
                default: ;
            endcase
        end
    end

    assign new_pc_o = new_pc_q;
    assign priv_o   = priv_q;
    assign sie_o    = sie_q;
    assign spie_o   = spie_q;
    assign spp_o    = spp_q;
    assign mie_o    = mie_q;
    assign mpie_o   = mpie_q;
    assign mpp_o    = mpp_q;
    assign scause_o = scause_q;
    assign sepc_o   = sepc_q;
    assign stval_o  = stval_q;
    assign mcause_o = mcause_q;
    assign mepc_o   = mepc_q;
    assign mtval_o  = mtval_q;

    // R2: a request is followed by the taken pulse
    a_r2_taken_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_i |=> taken_o);
    // R2: no pulse without a request one cycle earlier
    a_r2_no_spurious_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trap_req_i |=> !taken_o);
    // R3: interrupt entries carry the flag in the top cause bit
    a_r3_irq_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_i && trap_irq_i |=>
            ((priv_o == 2'd3) ? mcause_o[XLEN-1] : scause_o[XLEN-1]));
    // R5: a trap taken in machine mode stays in machine mode
    a_r5_machine_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_i && priv_o == 2'd3 |=> priv_o == 2'd3);
    // R6: supervisor entry leaves the supervisor enable clear
    a_r6_sie_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o && priv_o == 2'd1 |-> !sie_o);
    // R7: machine entry leaves the machine enable clear and supervisor EPC untouched
    a_r7_mie_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o && priv_o == 2'd3 |-> !mie_o);
    a_r7_sepc_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_i && priv_o == 2'd3 |=> $stable(sepc_o));
    // R9: handler address is always aligned
    a_r9_aligned_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o |-> new_pc_o[1:0] == 2'b00);
    // R10: the reserved privilege value never appears
    a_r10_no_reserved_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
        priv_o != 2'd2);

endmodule

// File: tb/trap_entry_unit_tb_top.sv
module trap_entry_unit_tb_top;

    localparam int unsigned XLEN    = 32;
    localparam int unsigned CAUSE_W = 6;
    localparam int unsigned DELEG_W = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n;
    logic               trap_req, trap_irq;
    logic [CAUSE_W-1:0] trap_cause;
    logic [XLEN-1:0]    trap_addr, trap_pc;
    logic               cfg_we;
    logic [2:0]         cfg_sel;
    logic [XLEN-1:0]    cfg_wdata;
    logic               taken;
    logic [XLEN-1:0]    new_pc;
    logic [1:0]         priv, mpp;
    logic               sie, spie, spp, mie, mpie;
    logic [XLEN-1:0]    scause, sepc, stval, mcause, mepc, mtval;

    trap_entry_unit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .DELEG_W(DELEG_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .trap_req_i(trap_req), .trap_irq_i(trap_irq), .trap_cause_i(trap_cause),
        .trap_addr_i(trap_addr), .trap_pc_i(trap_pc),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
        .taken_o(taken), .new_pc_o(new_pc), .priv_o(priv),
        .sie_o(sie), .spie_o(spie), .spp_o(spp), .mie_o(mie), .mpie_o(mpie), .mpp_o(mpp),
        .scause_o(scause), .sepc_o(sepc), .stval_o(stval),
        .mcause_o(mcause), .mepc_o(mepc), .mtval_o(mtval)
    );

    typedef struct {
        logic [31:0] pc;
        logic [1:0]  priv;
        logic [31:0] sc, se, st, mc, me, mt;
        logic        sie, spie, spp, mie, mpie;
        logic [1:0]  mpp;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;

    // reference model state, built from the requirements
    logic [1:0]  m_priv = 2'd3, m_mpp = 2'd0;
    logic        m_sie = 0, m_spie = 0, m_spp = 0, m_mie = 0, m_mpie = 0;
    logic [31:0] m_stvec = 0, m_mtvec = 0, m_pc = 0;
    logic [31:0] m_sc = 0, m_se = 0, m_st = 0, m_mc = 0, m_me = 0, m_mt = 0;
    logic [15:0] m_ed = 0, m_id = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // driver: presents one trap request, predicts the result, queues it
    task automatic issue(input logic irq, input logic [5:0] cause,
                         input logic [31:0] addr, input logic [31:0] pc, input string tag);
        logic [5:0] code;
        logic       dlg, keep;
        logic [15:0] msk;
        exp_t e;
        trap_req = 1; trap_irq = irq; trap_cause = cause; trap_addr = addr; trap_pc = pc;
        code = cause;
        if (!irq && cause == 6'd8) code = (m_priv == 2'd0) ? 6'd8 : (m_priv == 2'd1) ? 6'd9 : 6'd11;
        msk  = irq ? m_id : m_ed;
        dlg  = (m_priv != 2'd3) && (code < 6'd16) && msk[code[3:0]];
        keep = !irq && (code inside {6'd0, 6'd1, 6'd4, 6'd5, 6'd6, 6'd7, 6'd12, 6'd13, 6'd15});
        if (dlg) begin
            m_pc = m_stvec; m_sc = {irq, 25'd0, code}; m_se = pc; m_st = keep ? addr : 0;
            m_spie = m_sie; m_spp = (m_priv == 2'd1); m_sie = 0; m_priv = 2'd1;
        end else begin
            m_pc = m_mtvec; m_mc = {irq, 25'd0, code}; m_me = pc; m_mt = keep ? addr : 0;
            m_mpie = m_mie; m_mpp = m_priv; m_mie = 0; m_priv = 2'd3;
        end
        e.pc = m_pc; e.priv = m_priv; e.sc = m_sc; e.se = m_se; e.st = m_st;
        e.mc = m_mc; e.me = m_me; e.mt = m_mt; e.sie = m_sie; e.spie = m_spie;
        e.spp = m_spp; e.mie = m_mie; e.mpie = m_mpie; e.mpp = m_mpp; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        trap_req = 0;
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [31:0] data);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = data;
        case (sel)
            3'd0: m_stvec = {data[31:2], 2'b00};
            3'd1: m_mtvec = {data[31:2], 2'b00};
            3'd2: m_ed = data[15:0];
            3'd3: m_id = data[15:0];
            3'd4: m_priv = (data[1:0] == 2'd2) ? 2'd0 : data[1:0];
            3'd5: begin m_sie = data[0]; m_mie = data[1]; end
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 0;
    endtask

    // monitor: compares every taken pulse with the queued prediction
    always @(negedge clk) begin
        if (rst_n && taken) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected taken", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " new_pc"}, new_pc, e.pc);
                chk({e.tag, " priv"}, 32'(priv), 32'(e.priv));
                chk({e.tag, " scause"}, scause, e.sc);
                chk({e.tag, " sepc"}, sepc, e.se);
                chk({e.tag, " stval"}, stval, e.st);
                chk({e.tag, " mcause"}, mcause, e.mc);
                chk({e.tag, " mepc"}, mepc, e.me);
                chk({e.tag, " mtval"}, mtval, e.mt);
                chk({e.tag, " status"}, {26'd0, sie, spie, spp, mie, mpie, 1'b0},
                    {26'd0, e.sie, e.spie, e.spp, e.mie, e.mpie, 1'b0});
                chk({e.tag, " mpp"}, 32'(mpp), 32'(e.mpp));
            end
        end
    end

    initial begin
        #(4 * 50000);
        errors++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; trap_req = 0; trap_irq = 0; trap_cause = 0; trap_addr = 0; trap_pc = 0;
        cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 priv", 32'(priv), 32'd3);
        chk("R1 taken", 32'(taken), 32'd0);
        chk("R1 mcause", mcause, 0);
        chk("R1 scause", scause, 0);
        chk("R1 status", {27'd0, sie, spie, spp, mie, mpie}, 0);

        // R9 handler bases lose their low bits
        cfg(3'd1, 32'h8000_0103);
        cfg(3'd0, 32'h4000_0202);
        // R5 R7 R8: illegal-instruction in machine mode, no trap value
        issue(0, 6'd2, 32'h0000_dead, 32'h0000_1000, "R7 machine entry");
        @(negedge clk);

        cfg(3'd5, 32'h3);
        cfg(3'd2, 32'h0000_2102);   // exceptions 1, 8, 13
        cfg(3'd3, 32'h0000_0020);   // interrupt 5
        cfg(3'd4, 32'h0);
        chk("R11 priv write", 32'(priv), 32'd0);
        // R4 R6: user environment call, delegated
        issue(0, 6'd8, 32'h1111_0000, 32'h0000_2000, "R4 R6 user ecall");
        @(negedge clk);
        // R4 R5: supervisor environment call, code 9 not delegated
        issue(0, 6'd8, 32'h1111_0004, 32'h0000_2004, "R4 R5 super ecall");
        @(negedge clk);
        cfg(3'd4, 32'h1);
        cfg(3'd5, 32'h1);
        // R8 R6: load page fault in supervisor, delegated, keeps address
        issue(0, 6'd13, 32'hCAFE_0010, 32'h0000_3000, "R8 R6 page fault");
        @(negedge clk);
        // R12 R3: interrupt 13 not in interrupt mask
        issue(1, 6'd13, 32'hCAFE_0020, 32'h0000_3004, "R12 R3 irq13 machine");
        @(negedge clk);
        // R10 reserved privilege maps to user
        cfg(3'd4, 32'h2);
        chk("R10 reserved priv", 32'(priv), 32'd0);
        // R3 R12: interrupt 5 delegated, trap value zero
        issue(1, 6'd5, 32'hCAFE_0030, 32'h0000_4000, "R3 R12 irq5 super");
        @(negedge clk);
        // R12: cause beyond mask width stays in machine mode even with full mask
        cfg(3'd2, 32'hFFFF_FFFF);
        // R11: configuration write during trap is ignored
        cfg_we = 1; cfg_sel = 3'd1; cfg_wdata = 32'h0000_1234;
        issue(0, 6'd20, 32'hCAFE_0040, 32'h0000_5000, "R12 R11 cause20");
        cfg_we = 0;
        @(negedge clk);
        // R4 R5 R11: machine ecall keeps machine mode, old base still used
        issue(0, 6'd8, 32'hCAFE_0050, 32'h0000_5004, "R4 R11 machine ecall");
        @(negedge clk);
        // R8: store misaligned in machine mode keeps address
        issue(0, 6'd6, 32'hCAFE_0061, 32'h0000_5008, "R8 R5 store misaligned");
        @(negedge clk);
        // R2 back-to-back requests from supervisor
        cfg(3'd4, 32'h1);
        issue(0, 6'd1, 32'hCAFE_0070, 32'h0000_6000, "R2 R6 back to back A");
        issue(0, 6'd1, 32'hCAFE_0074, 32'h0000_6004, "R2 R6 back to back B");
        issue(1, 6'd7, 32'hCAFE_0078, 32'h0000_6008, "R2 R7 back to back C");
        repeat (3) @(negedge clk);
        chk("R2 queue drained", 32'(exp_q.size()), 32'd0);
        chk("R2 taken idle", 32'(taken), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule